// File: doc/BRIEF.md
# Inter-Processor Mailbox Doorbell Unit

This block holds sixteen 32-bit doorbell words, grouped as four words for each of four processor cores. A core rings another core by writing a bit pattern into one of that core's words; the target core sees a level flag for the word, reads the word to learn which bits were raised, and writes the same pattern back to clear them. Each word has two write views. One view ORs the written data into the word. The other view clears the bits written as one and also serves reads.

The register bus is a plain strobe interface with a byte address, write data, a write strobe, a read strobe and registered read data. Each of the sixteen flags is high for as long as its word holds any set bit. The flags are meant to feed a separate interrupt router.

Top module: `mbx_doorbell`

## Requirements
- R1: During and after reset, every word is zero, every bit of mbox_flag is low, and bus_rdata is zero.
- R2: A write with bus_wr high to byte offset 0x80 + 16*c + 4*m (core c and slot m, each 0..3) ORs bus_wdata into word 4*c+m at that clock edge.
- R3: A write to byte offset 0xC0 + 16*c + 4*m clears each bit of word 4*c+m whose bus_wdata bit is 1. Bits written as 0 keep their value.
- R4: mbox_flag[4*c+m] is high exactly when word 4*c+m is nonzero. It follows a write in the cycle after the write edge, and it only drops when every bit of the word has been cleared.
- R5: A read with bus_rd high at a clear-view offset returns that word on bus_rdata in the cycle after the read edge. In any cycle after an edge where bus_rd was low, bus_rdata is zero.
- R6: A read at a set-view offset returns zero.
- R7: Accesses to offsets below 0x80, or with address bits [1:0] nonzero, change no word and read as zero.
- R8: A read and a write issued in the same cycle to the same clear-view offset return the word as it was before that write.
- R9: A write changes only the addressed word. All other words and flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| mbox_flag | output | 16 | Per-word nonzero flags, index 4*core+slot |

## Verification
A write takes effect at the clock edge that samples bus_wr. Both the word and its flag are therefore visible one cycle after the stimulus. The bench drives each access on a falling edge and checks the flags on the next falling edge, which is after exactly one rising edge. Read data is also due one cycle after the read strobe, so the bench samples bus_rdata on the falling edge that follows the capturing rising edge. It samples before it removes the strobe. When a read and a write share a cycle, the expected read value is taken from the bench model before the write is applied to it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int NUM_CORES      = 4;
    localparam int BOXES_PER_CORE = 4;
    localparam int DATA_W         = 32;
    localparam int ADDR_W         = 8;
    localparam logic [ADDR_W-1:0] SET_BASE = 8'h80;
    localparam logic [ADDR_W-1:0] CLR_BASE = 8'hC0;

    // Which register view an address falls in.
    typedef enum logic [1:0] {
        VIEW_NONE = 2'd0,
        VIEW_SET  = 2'd1,
        VIEW_CLR  = 2'd2
    } view_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int NUM_CORES      = mbx_pkg::NUM_CORES,
    parameter int BOXES_PER_CORE = mbx_pkg::BOXES_PER_CORE,
    parameter int ADDR_W         = mbx_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0] SET_BASE = mbx_pkg::SET_BASE,
    parameter logic [ADDR_W-1:0] CLR_BASE = mbx_pkg::CLR_BASE,
    localparam int NUM_BOX = NUM_CORES * BOXES_PER_CORE,
    localparam int IDX_W   = $clog2(NUM_BOX)
) (
    input  logic [ADDR_W-1:0] addr,
    output view_e             view,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] VIEW_BYTES = (ADDR_W+1)'(NUM_BOX * 4);

    logic [ADDR_W:0] off_set;
    logic [ADDR_W:0] off_clr;
    logic            aligned;
    logic            in_set;
    logic            in_clr;

    always_comb begin
        off_set = {1'b0, addr} - {1'b0, SET_BASE};
        off_clr = {1'b0, addr} - {1'b0, CLR_BASE};
        aligned = (addr[1:0] == 2'b00);
        in_set  = aligned && (addr >= SET_BASE) && (off_set < VIEW_BYTES);
        in_clr  = aligned && (addr >= CLR_BASE) && (off_clr < VIEW_BYTES);
        // The set view takes priority if the two views were ever placed to overlap.
        if (in_set) begin
            view = VIEW_SET;
            idx  = off_set[IDX_W+1:2];
        end else if (in_clr) begin
            view = VIEW_CLR;
            idx  = off_clr[IDX_W+1:2];
        end else begin
            view = VIEW_NONE;
            idx  = '0;
        end
    end
endmodule

// File: rtl/mbx_word.sv
module mbx_word #(
    parameter int DATA_W = mbx_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] word,
    output logic              flag
);
    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } word_state_t;

    word_state_t st_d;
    word_state_t st_q;

    always_comb begin
        st_d = st_q;
        // A bit that is set and cleared in the same cycle ends up set.
        st_d.bits = (st_q.bits & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.bits;
    assign flag = |st_q.bits;
endmodule

// File: rtl/mbx_readmux.sv
module mbx_readmux
    import mbx_pkg::*;
#(
    parameter int NUM_BOX = 16,
    parameter int DATA_W  = mbx_pkg::DATA_W,
    localparam int IDX_W  = $clog2(NUM_BOX)
) (
    input  logic [NUM_BOX-1:0][DATA_W-1:0] words,
    input  logic                           rd,
    input  view_e                          view,
    input  logic [IDX_W-1:0]               idx,
    output logic [DATA_W-1:0]              rdata_next
);
    always_comb begin
        rdata_next = '0;
        if (rd && (view == VIEW_CLR)) begin
            rdata_next = words[idx];
        end
    end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int NUM_CORES      = mbx_pkg::NUM_CORES,
    parameter int BOXES_PER_CORE = mbx_pkg::BOXES_PER_CORE,
    parameter int DATA_W         = mbx_pkg::DATA_W,
    parameter int ADDR_W         = mbx_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0] SET_BASE = mbx_pkg::SET_BASE,
    parameter logic [ADDR_W-1:0] CLR_BASE = mbx_pkg::CLR_BASE,
    localparam int NUM_BOX = NUM_CORES * BOXES_PER_CORE,
    localparam int IDX_W   = $clog2(NUM_BOX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_BOX-1:0]  mbox_flag
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    view_e                          acc_view;
    logic [IDX_W-1:0]               acc_idx;
    logic [NUM_BOX-1:0][DATA_W-1:0] words;
    logic [DATA_W-1:0]              rdata_next;
    rd_state_t                      rd_d;
    rd_state_t                      rd_q;

    mbx_decode #(
        .NUM_CORES      (NUM_CORES),
        .BOXES_PER_CORE (BOXES_PER_CORE),
        .ADDR_W         (ADDR_W),
        .SET_BASE       (SET_BASE),
        .CLR_BASE       (CLR_BASE)
    ) i_decode (
        .addr (bus_addr),
        .view (acc_view),
        .idx  (acc_idx)
    );

    for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
        logic hit;
        logic [DATA_W-1:0] set_mask;
        logic [DATA_W-1:0] clr_mask;

        always_comb begin
            hit      = bus_wr && (acc_idx == IDX_W'(b));
            set_mask = (hit && acc_view == VIEW_SET) ? bus_wdata : '0;
            clr_mask = (hit && acc_view == VIEW_CLR) ? bus_wdata : '0;
        end

        mbx_word #(
            .DATA_W (DATA_W)
        ) i_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_mask),
            .clr_mask (clr_mask),
            .word     (words[b]),
            .flag     (mbox_flag[b])
        );
    end

    mbx_readmux #(
        .NUM_BOX (NUM_BOX),
        .DATA_W  (DATA_W)
    ) i_readmux (
        .words      (words),
        .rd         (bus_rd),
        .view       (acc_view),
        .idx        (acc_idx),
        .rdata_next (rdata_next)
    );

    always_comb begin
        rd_d       = rd_q;
        rd_d.rdata = rdata_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
    parameter int NUM_BOX = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] SET_BASE = 8'h80,
    parameter logic [ADDR_W-1:0] CLR_BASE = 8'hC0,
    localparam int IDX_W  = $clog2(NUM_BOX)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_BOX-1:0] mbox_flag
);
    localparam int SPAN = NUM_BOX * 4;

    logic             is_set;
    logic             is_clr;
    logic [IDX_W-1:0] slot;
    int unsigned      a;

    always_comb begin
        a      = 32'(bus_addr);
        is_set = (bus_addr[1:0] == 2'b00) && (a >= 32'(SET_BASE)) && (a < 32'(SET_BASE) + SPAN);
        is_clr = !is_set && (bus_addr[1:0] == 2'b00) && (a >= 32'(CLR_BASE)) && (a < 32'(CLR_BASE) + SPAN);
        slot   = is_set ? IDX_W'((a - 32'(SET_BASE)) >> 2) : IDX_W'((a - 32'(CLR_BASE)) >> 2);
    end

    // R2: a nonzero set-view write raises the flag of the addressed word
    p_set_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_set && bus_wdata != '0) |=> mbox_flag[$past(slot)]);

    // R3: clearing every bit lowers the flag of the addressed word
    p_full_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_clr && bus_wdata == '1) |=> !mbox_flag[$past(slot)]);

    // R4: without a write, the flags cannot move
    p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(mbox_flag));

    // R5: idle read strobe gives zero read data
    p_idle_rdata_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

    // R5: read data agrees with the flag the word had when read
    p_read_matches_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_clr) |=> ((bus_rdata != '0) == $past(mbox_flag[slot])));

    // R6: set-view reads return zero
    p_set_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_set) |=> bus_rdata == '0);

    // R7: unmapped writes leave every flag alone
    p_unmapped_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !is_set && !is_clr) |=> $stable(mbox_flag));

    // R9: at most the addressed flag may change on a write
    p_only_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> $countones(mbox_flag ^ $past(mbox_flag)) <= 1);
endmodule

bind mbx_doorbell mbx_doorbell_chk #(
    .NUM_BOX  (NUM_BOX),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .SET_BASE (SET_BASE),
    .CLR_BASE (CLR_BASE)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .mbox_flag (mbox_flag)
);

// File: tb/test_mbx_doorbell.sv
`timescale 1ns/1ps
module test_mbx_doorbell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] mbox_flag;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    logic [31:0] model [16];

    always #2.5 clk = ~clk;

    mbx_doorbell i_mbx_doorbell (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .mbox_flag (mbox_flag)
    );

    // 0 = unmapped, 1 = set view, 2 = clear view
    function automatic int kind_of(logic [7:0] a);
        if (a[1:0] != 2'b00) return 0;
        if (a >= 8'h80 && a < 8'hC0) return 1;
        if (a >= 8'hC0) return 2;
        return 0;
    endfunction

    function automatic int slot_of(logic [7:0] a);
        return int'(a[5:2]);
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        return (kind_of(a) == 2) ? model[slot_of(a)] : 32'h0;
    endfunction

    function automatic logic [15:0] exp_flags();
        logic [15:0] f;
        for (int i = 0; i < 16; i++) f[i] = (model[i] != 0);
        return f;
    endfunction

    function automatic void apply_write(logic [7:0] a, logic [31:0] d);
        if (kind_of(a) == 1) model[slot_of(a)] = model[slot_of(a)] | d;
        else if (kind_of(a) == 2) model[slot_of(a)] = model[slot_of(a)] & ~d;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_flags(string req);
        logic [15:0] e;
        e = exp_flags();
        check(mbox_flag == e, req, 32'(mbox_flag), 32'(e));
    endtask

    // One bus cycle: optional write and/or read at one address.
    task automatic access(logic [7:0] a, logic [31:0] d, bit wr, bit rd, string req);
        logic [31:0] er;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = rd;
        er = rd ? exp_read(a) : 32'h0;     // R8: value before the write
        if (wr) apply_write(a, d);
        @(negedge clk);
        check(bus_rdata == er, req, bus_rdata, er);
        check_flags(req);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] set_addr(int c, int m);
        return 8'(8'h80 + 16 * c + 4 * m);
    endfunction
    function automatic logic [7:0] clr_addr(int c, int m);
        return 8'(8'hC0 + 16 * c + 4 * m);
    endfunction

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(mbox_flag == 16'h0, "R1 flags in reset", 32'(mbox_flag), 32'h0);
        check(bus_rdata == 32'h0, "R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mbox_flag == 16'h0, "R1 flags after reset", 32'(mbox_flag), 32'h0);
        access(clr_addr(3, 3), 0, 0, 1, "R1 word reads zero");

        // R2 / R4: set ORs in, flag rises, read back through clear view
        access(set_addr(1, 2), 32'h0000_0005, 1, 0, "R2 first set");
        access(set_addr(1, 2), 32'h0000_0100, 1, 0, "R2 second set ORs");
        access(clr_addr(1, 2), 0, 0, 1, "R5 read back 0x105");
        check(bus_rdata == 32'h105, "R2 merged value", bus_rdata, 32'h105);
        // R6: set-view read
        access(set_addr(1, 2), 0, 0, 1, "R6 set view reads zero");
        // R3 / R4: partial clear keeps flag, full clear drops it
        access(clr_addr(1, 2), 32'h0000_0001, 1, 0, "R3 partial clear");
        check(mbox_flag[6] == 1'b1, "R4 flag held while bits remain", 32'(mbox_flag[6]), 1);
        access(clr_addr(1, 2), 32'h0000_0000, 1, 0, "R3 zero-write keeps bits");
        access(clr_addr(1, 2), 32'h0000_0104, 1, 0, "R3 final clear");
        check(mbox_flag[6] == 1'b0, "R4 flag drops at zero", 32'(mbox_flag[6]), 0);
        // R9: neighbours untouched
        access(set_addr(0, 0), 32'h8000_0000, 1, 0, "R9 first word");
        access(set_addr(3, 3), 32'h0000_0001, 1, 0, "R9 last word");
        access(clr_addr(0, 1), 32'hFFFF_FFFF, 1, 0, "R9 clear other word");
        // R7: unmapped and misaligned
        access(8'h40, 32'hFFFF_FFFF, 1, 1, "R7 low offset");
        access(8'h81, 32'hFFFF_FFFF, 1, 0, "R7 misaligned set");
        access(8'hC2, 32'hFFFF_FFFF, 1, 1, "R7 misaligned clear");
        access(clr_addr(0, 0), 0, 0, 1, "R7 word intact");
        // R8: read and clear in the same cycle
        access(clr_addr(0, 0), 32'h8000_0000, 1, 1, "R8 old value on read");
        access(clr_addr(0, 0), 0, 0, 1, "R8 word now zero");

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int k;
            int c;
            int m;
            logic [31:0] d;
            k = int'($urandom_range(0, 6));
            c = int'($urandom_range(0, 3));
            m = int'($urandom_range(0, 3));
            d = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : ($urandom() & $urandom() & $urandom());
            case (k)
                0, 1: access(set_addr(c, m), d, 1, 0, "R2 random set");
                2:    access(clr_addr(c, m), d, 1, 0, "R3 random clear");
                3:    access(clr_addr(c, m), 0, 0, 1, "R5 random read");
                4:    access(set_addr(c, m), 0, 0, 1, "R6 random set read");
                5:    access(8'($urandom_range(0, 255)), d, 1, 1, "R7 random address");
                default: access(clr_addr(c, m), d, 1, 1, "R8 random read-clear");
            endcase
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule